// File: doc/BRIEF.md
# Ship Mode Power-State Controller

This block decides when a battery-powered device drops into its deepest latched-off state and when it comes back out. In that state the battery switch and the core supply are both turned off. Only the input-supply-valid flag and the push-button input are watched.

A host asks for the state by setting an enable bit through a one-bit register write port. The request waits while either of two things blocks it: the input supply is valid, or the button is held down. The request survives a watchdog expiry and completes once nothing blocks it. The host can withdraw it at any time by writing a zero. Inserting a battery while no input supply is present forces entry on its own. The enable bit clears itself on entry, so a later wake does not re-enter at once.

The block leaves the state in two ways. The first is the input supply becoming valid. The second is a button press of at least `WAKE_TICKS` clock cycles followed by a release, and this one counts only if the battery voltage is above its threshold at the moment of release. The button input is asynchronous and goes through a synchronizer.

Top module: `shipm_ctrl`

## Requirements
- R1: After reset the block is in the run state: `ship_o`=0, `bat_sw_en_o`=1, `core_en_o`=1, `req_o`=0.
- R2: `bat_sw_en_o` and `core_en_o` are both 0 exactly when `ship_o` is 1, and both 1 otherwise.
- R3: A write with `reg_wdata_i`=1 sets `req_o` at the next edge. With `supply_ok_i`=0 and the synchronized button released, `ship_o` goes to 1 at the following edge and `req_o` returns to 0 at that same edge.
- R4: While `supply_ok_i`=1, a pending request does not cause entry. Entry follows one edge after the supply goes invalid.
- R5: While the synchronized button is low (pressed), a pending request does not cause entry. Entry follows one edge after the synchronized button goes high. The synchronizer adds `SYNC_STAGES` cycles.
- R6: Writing `reg_wdata_i`=0 clears `req_o`, which cancels a pending entry.
- R7: A `wdog_expire_i` pulse leaves `req_o` unchanged, and a pending entry still completes when its blocks clear.
- R8: A `bat_insert_i` pulse while in the run state with `supply_ok_i`=0 causes entry at that edge. With `supply_ok_i`=1 it has no effect.
- R9: In the ship state, `supply_ok_i`=1 returns the block to the run state at the next edge.
- R10: In the ship state, if the synchronized button has been low for at least `WAKE_TICKS` cycles and is then released while `bat_ok_i`=1, the block returns to the run state at the edge of the first released cycle.
- R11: In the ship state, a press shorter than `WAKE_TICKS` cycles, or any release with `bat_ok_i`=0, leaves the block in the ship state. The hold count restarts from zero after each release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Write strobe for the ship enable bit |
| reg_wdata_i | input | 1 | Value written to the ship enable bit |
| supply_ok_i | input | 1 | Input supply above its undervoltage threshold |
| bat_insert_i | input | 1 | Battery-inserted event, one-cycle pulse |
| bat_ok_i | input | 1 | Battery above the highest undervoltage threshold |
| wdog_expire_i | input | 1 | Host watchdog expired, one-cycle pulse |
| btn_ni | input | 1 | Push button, active low, asynchronous |
| bat_sw_en_o | output | 1 | Battery switch enable |
| core_en_o | output | 1 | Core power enable |
| ship_o | output | 1 | 1 while in the ship state |
| req_o | output | 1 | Current value of the ship enable bit |

## Verification
The bench probes the exact press length around `WAKE_TICKS`:
- A press of one cycle less must not wake the block.
- A counter that is off by one would wake on that press, or fail to wake on a press of exactly `WAKE_TICKS` cycles.

It also splits a long hold into two short presses. A counter that keeps its count across a release would add the two together and wake the block by mistake.

The deferred-entry cases check three ways the request can go wrong:
- The supply is held valid, or the button is held, and the block must not enter. A design that ignores either block would enter too early.
- A watchdog pulse arrives while the request is pending. A design that clears the bit on that pulse would never enter.
- The host writes a zero while the request is pending. A design that keeps the request would enter anyway.

Two more cases cover the release rules:
- A release with the battery low must not wake the block. A design that ignores the battery check would wake.
- A battery insertion while the supply is valid must have no effect. A design that ignores the supply on that path would enter.

// File: rtl/shipm_pkg.sv
package shipm_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SHIP = 1'b1
  } shipm_state_e;
endpackage

// File: rtl/shipm_btn_sync.sv
module shipm_btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic btn_s_o
);
  logic [STAGES-1:0] q;

  // reset to released so no phantom press appears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], btn_ni};
  end

  assign btn_s_o = q[STAGES-1];
endmodule

// File: rtl/shipm_wake_det.sv
module shipm_wake_det #(
  parameter int unsigned WAKE_TICKS = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic btn_s_i,
  output logic wake_o
);
  localparam int unsigned CNT_W = $clog2(WAKE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAKE_TICKS);

  logic [CNT_W-1:0] cnt;
  logic             btn_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      btn_d <= 1'b1;
    end else begin
      btn_d <= btn_s_i;
      if (!arm_i || btn_s_i) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  // release edge after a long enough hold
  assign wake_o = arm_i && btn_s_i && !btn_d && (cnt >= CNT_MAX);

  a_r11_count_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_s_i |=> (cnt == '0));
endmodule

// File: rtl/shipm_req_reg.sv
module shipm_req_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic clr_i,
  output logic req_o
);
  // auto-clear on entry wins over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   req_o <= 1'b0;
    else if (clr_i) req_o <= 1'b0;
    else if (wr_i)  req_o <= wdata_i;
  end

  a_r6_write_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i) |=> !req_o);
endmodule

// File: rtl/shipm_fsm.sv
module shipm_fsm
  import shipm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic supply_ok_i,
  input  logic bat_insert_i,
  input  logic btn_s_i,
  input  logic wake_i,
  input  logic bat_ok_i,
  output logic ship_o,
  output logic enter_o
);
  shipm_state_e st_q, st_d;
  logic leave;

  assign enter_o = (st_q == ST_RUN) && !supply_ok_i &&
                   ((req_i && btn_s_i) || bat_insert_i);
  assign leave   = (st_q == ST_SHIP) && (supply_ok_i || (wake_i && bat_ok_i));

  always_comb begin
    st_d = st_q;
    if (enter_o)    st_d = ST_SHIP;
    else if (leave) st_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign ship_o = (st_q == ST_SHIP);

  a_r4_supply_blocks_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ship_o && supply_ok_i) |=> !ship_o);
  a_r5_button_blocks_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ship_o && !btn_s_i && !bat_insert_i) |=> !ship_o);
  a_r9_supply_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ship_o && supply_ok_i) |=> !ship_o);
  a_r11_low_batt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ship_o && !supply_ok_i && !bat_ok_i) |=> ship_o);
endmodule

// File: rtl/shipm_ctrl.sv
module shipm_ctrl #(
  parameter int unsigned WAKE_TICKS  = 1000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_wr_i,
  input  logic reg_wdata_i,
  input  logic supply_ok_i,
  input  logic bat_insert_i,
  input  logic bat_ok_i,
  input  logic wdog_expire_i,
  input  logic btn_ni,
  output logic bat_sw_en_o,
  output logic core_en_o,
  output logic ship_o,
  output logic req_o
);
  logic btn_s, wake, enter;

  shipm_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_ni(btn_ni), .btn_s_o(btn_s)
  );

  shipm_wake_det #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(ship_o), .btn_s_i(btn_s), .wake_o(wake)
  );

  // watchdog expiry intentionally has no path into the request bit
  shipm_req_reg u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .clr_i(enter), .req_o(req_o)
  );

  shipm_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_o), .supply_ok_i(supply_ok_i),
    .bat_insert_i(bat_insert_i), .btn_s_i(btn_s), .wake_i(wake),
    .bat_ok_i(bat_ok_i), .ship_o(ship_o), .enter_o(enter)
  );

  assign bat_sw_en_o = !ship_o;
  assign core_en_o   = !ship_o;

  a_r2_rails_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ship_o |-> (!bat_sw_en_o && !core_en_o));
  a_r3_bit_clears_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ship_o) |-> !req_o);
  a_r7_wdog_keeps_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_expire_i && req_o && !reg_wr_i && !enter) |=> req_o);
endmodule

// File: tb/tb_shipm_ctrl.sv
module tb_shipm_ctrl;
  localparam int unsigned W = 16;

  typedef struct {
    string tag;
    logic  ship;
    logic  req;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_wr = 0, reg_wdata = 0, supply_ok = 0, bat_insert = 0;
  logic bat_ok = 1, wdog = 0, btn_n = 1;
  logic bat_sw_en, core_en, ship, req;

  exp_t q[$];
  int   vectors = 0, miscompares = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  shipm_ctrl #(.WAKE_TICKS(W), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .supply_ok_i(supply_ok), .bat_insert_i(bat_insert), .bat_ok_i(bat_ok),
    .wdog_expire_i(wdog), .btn_ni(btn_n), .bat_sw_en_o(bat_sw_en),
    .core_en_o(core_en), .ship_o(ship), .req_o(req)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(string tag, logic s, logic r);
    exp_t e;
    e.tag = tag; e.ship = s; e.req = r;
    q.push_back(e);
    #0;
  endtask

  task automatic wr_bit(logic v);
    reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic press(int k);
    btn_n = 0;
    step(k);
    btn_n = 1;
  endtask

  // monitor: compares as soon as an expectation is queued (at a negedge)
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      e = q.pop_front();
      vectors++;
      if (ship !== e.ship || req !== e.req || bat_sw_en !== !e.ship ||
          core_en !== !e.ship) begin
        miscompares++;
        $display("FAIL %s: ship=%b req=%b bat_sw=%b core=%b expected ship=%b req=%b bat_sw=%b core=%b",
                 e.tag, ship, req, bat_sw_en, core_en, e.ship, e.req, !e.ship, !e.ship);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    expect_st("R1 reset", 0, 0);

    // R3 direct entry, bit auto-clears (R2 rails checked by monitor)
    wr_bit(1);
    expect_st("R3 bit set", 0, 1);
    step(1);
    expect_st("R3/R2 entered", 1, 0);

    // R9 supply wake
    supply_ok = 1;
    step(1);
    expect_st("R9 supply wake", 0, 0);

    // R4 deferred by supply
    wr_bit(1);
    step(5);
    expect_st("R4 held by supply", 0, 1);
    supply_ok = 0;
    step(1);
    expect_st("R4 entry after supply gone", 1, 0);
    supply_ok = 1; step(1); supply_ok = 0; step(2);
    expect_st("R9 wake, no reentry", 0, 0);

    // R7 watchdog keeps request
    supply_ok = 1;
    wr_bit(1);
    wdog = 1; step(1); wdog = 0;
    step(3);
    expect_st("R7 req kept after wdog", 0, 1);
    supply_ok = 0;
    step(1);
    expect_st("R7 pending entry completes", 1, 0);
    supply_ok = 1; step(1); supply_ok = 0; step(1);
    expect_st("R9 wake again", 0, 0);

    // R6 host cancel
    supply_ok = 1;
    wr_bit(1);
    step(2);
    wr_bit(0);
    expect_st("R6 req cleared", 0, 0);
    supply_ok = 0;
    step(4);
    expect_st("R6 no entry after cancel", 0, 0);

    // R5 deferred by held button
    btn_n = 0;
    step(3);
    wr_bit(1);
    step(3);
    expect_st("R5 held by button", 0, 1);
    btn_n = 1;
    step(2);
    expect_st("R5 sync latency", 0, 1);
    step(1);
    expect_st("R5 entry after release", 1, 0);

    // R11 / R10 press length boundary
    press(W - 1);
    step(3);
    expect_st("R11 short press", 1, 0);
    press(W);
    step(2);
    expect_st("R10 before release seen", 1, 0);
    step(1);
    expect_st("R10 exact wake length", 0, 0);

    // R8 battery insertion entry
    bat_insert = 1; step(1); bat_insert = 0;
    expect_st("R8 insert enters", 1, 0);

    // R11 low battery blocks button wake
    bat_ok = 0;
    press(40);
    step(3);
    expect_st("R11 low battery", 1, 0);
    bat_ok = 1;

    // R11 count restarts on release
    press(10);
    step(3);
    press(10);
    step(3);
    expect_st("R11 split presses", 1, 0);
    press(20);
    step(3);
    expect_st("R10 long press wake", 0, 0);

    // R8 insertion with supply valid is ignored
    supply_ok = 1;
    bat_insert = 1; step(1); bat_insert = 0;
    step(1);
    expect_st("R8 insert with supply", 0, 0);
    supply_ok = 0;
    step(2);
    expect_st("R8 stays run", 0, 0);

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule